// File: doc/BRIEF.md
# Exception entry sequencer

This block takes a processor core into an exception handler and back out. When the pipeline raises an exception request, the block saves the restart address, records the cause and the fault address, sets the exception-level bit in its status flags, and works out the handler address from the boot-vector flag, the exception base and the kind of exception. A non-maskable interrupt takes a separate path with its own saved address and a fixed reset-area target. A return strobe undoes the deepest active level and hands back the saved address. The front end then fetches from `redirect_pc` for the one cycle in which `redirect_valid` is high.

The control is a three-state machine. `ST_IDLE` waits. On a request, any state moves to `ST_TAKE` (transition "take"). On a return strobe with no request, any state moves to `ST_RETURN` (transition "resume"). With neither strobe, any state falls back to `ST_IDLE` (transition "settle"). The redirect pulse is high in `ST_TAKE` and in `ST_RETURN`. A narrow write path loads the status flags, the context register or the entry-high register, so that the pipeline can set them up.

Top module: `exc_entry_unit`

## Requirements
- R1: When a non-NMI request arrives with the exception-level flag (`status_out[0]`) clear, `epc_out` becomes `pc_in`, or `pc_in - 4` when `in_delay_slot` is high. The delay bit `cause_out[31]` takes the value of `in_delay_slot`, and the exception-level flag is set.
- R2: When a non-NMI request arrives with the exception-level flag already set, `epc_out` and `cause_out[31]` keep their values. The cause code is still written and the flag stays set.
- R3: The vector base is 0xBFC00200 when the boot flag (`status_out[2]`) is set. Otherwise it is `exc_base_hi` placed at bits 31:10, with bits 9:0 zero.
- R4: The handler offset added to the base is 0x000 for a refill request taken with the exception-level flag clear, 0x200 for cause code 0 with `iv_in` high, and 0x180 in every other case.
- R5: The cause code `req_code` is written to `cause_out[6:2]`. For code 11, `req_ce` is also written to `cause_out[29:28]`. `cause_out[23]` reflects `iv_in`.
- R6: For cause codes 1 to 5, `badvaddr_out` takes `fault_addr`, `context_out[22:4]` takes `fault_addr[31:13]` with its other bits kept, and `entryhi_out` becomes `fault_addr[31:13]` at bits 31:13, zero at bits 12:8 and its old bits 7:0. For other codes these three registers are unchanged.
- R7: A request with `req_nmi` high writes `errorepc_out` using the rule of R1, sets the error-level, boot and NMI flags (`status_out[1]`, `[2]`, `[3]`), leaves `epc_out` alone and targets 0xBFC00000.
- R8: Register updates and `redirect_pc` appear on the clock edge that samples the request, and `redirect_valid` is high for exactly the following cycle unless another strobe arrives.
- R9: A return strobe clears the error-level flag and targets `errorepc_out` when that flag is set. Otherwise it clears the exception-level flag and targets `epc_out`.
- R10: A request and a return strobe in the same cycle: the request is taken and the return strobe has no effect.
- R11: After reset the status flags read 4'b0100 (boot flag only), the saved addresses, cause, fault registers and redirect outputs are zero.
- R12: A write with `csr_wr_en` loads `csr_wr_data` into the status flags (select 0, bits 3:0), `context_out` (select 1) or `entryhi_out` (select 2). It is ignored in a cycle that carries a request or a return strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Exception request strobe |
| req_code | input | 5 | Cause code of the request |
| req_refill | input | 1 | Request is a translation refill miss |
| req_nmi | input | 1 | Request is a non-maskable interrupt |
| req_ce | input | 2 | Coprocessor number for code 11 |
| pc_in | input | 32 | Address of the faulting instruction |
| in_delay_slot | input | 1 | Faulting instruction sits in a branch delay slot |
| fault_addr | input | 32 | Faulting virtual address |
| exc_base_hi | input | 22 | Exception base, bits 31:10 |
| iv_in | input | 1 | Separate interrupt vector enable |
| eret_valid | input | 1 | Exception return strobe |
| csr_wr_en | input | 1 | Register load strobe |
| csr_wr_sel | input | 2 | Load target: 0 status, 1 context, 2 entry-high |
| csr_wr_data | input | 32 | Load data |
| redirect_valid | output | 1 | One-cycle fetch redirect pulse |
| redirect_pc | output | 32 | New fetch address |
| epc_out | output | 32 | Saved exception restart address |
| errorepc_out | output | 32 | Saved NMI restart address |
| cause_out | output | 32 | Cause register view |
| status_out | output | 4 | Flags: 0 exception level, 1 error level, 2 boot, 3 NMI |
| badvaddr_out | output | 32 | Last faulting address |
| context_out | output | 32 | Context register |
| entryhi_out | output | 32 | Entry-high register |

## Verification
The request and the return strobe can both land on one clock edge, and so can the request and a register load. Each pair is provoked by raising both strobes in the same drive cycle while the exception-level flag is set. The result is judged at the ports: the redirect target must be the exception vector and not the saved address, and the exception-level flag must still read as set on the following cycle, which shows that neither the return nor the load took effect. The table-driven part walks the vector-base and offset choices across both flag states.

// File: rtl/exc_pkg.sv
package exc_pkg;

    localparam int AW        = 32;
    localparam int BASE_LSB  = 10;
    localparam int PAIR_W    = 13;
    localparam int ID_W      = 8;
    localparam int CTX_LSB   = 4;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_TAKE   = 2'd1,
        ST_RETURN = 2'd2
    } exc_state_e;

    localparam logic [4:0] EC_INT  = 5'd0;
    localparam logic [4:0] EC_MOD  = 5'd1;
    localparam logic [4:0] EC_ADES = 5'd5;
    localparam logic [4:0] EC_CPU  = 5'd11;

    localparam logic [1:0] SEL_STATUS  = 2'd0;
    localparam logic [1:0] SEL_CONTEXT = 2'd1;
    localparam logic [1:0] SEL_ENTRYHI = 2'd2;

    typedef struct packed {
        logic nmi;
        logic bev;
        logic erl;
        logic exl;
    } status_t;

    function automatic logic is_addr_fault(input logic [4:0] code);
        return (code >= EC_MOD) && (code <= EC_ADES);
    endfunction

endpackage

// File: rtl/exc_vector_sel.sv
module exc_vector_sel
    import exc_pkg::*;
#(
    parameter int          W          = AW,
    parameter int          LSB        = BASE_LSB,
    parameter logic [W-1:0] BOOT_BASE = 32'hBFC0_0200,
    parameter logic [W-1:0] OFF_MISS  = 32'h0000_0000,
    parameter logic [W-1:0] OFF_INTV  = 32'h0000_0200,
    parameter logic [W-1:0] OFF_GEN   = 32'h0000_0180
) (
    input  logic             bev,
    input  logic [W-LSB-1:0] base_hi,
    input  logic [4:0]       code,
    input  logic             refill,
    input  logic             exl,
    input  logic             iv,
    output logic [W-1:0]     vec
);

    logic [W-1:0] base;
    logic [W-1:0] offset;

    always_comb begin
        base = bev ? BOOT_BASE : {base_hi, {LSB{1'b0}}};
        if (refill && !exl) begin
            offset = OFF_MISS;
        end else if ((code == EC_INT) && iv) begin
            offset = OFF_INTV;
        end else begin
            offset = OFF_GEN;
        end
    end

    assign vec = base + offset;

endmodule

// File: rtl/exc_fault_capture.sv
module exc_fault_capture
    import exc_pkg::*;
#(
    parameter int W    = AW,
    parameter int PW   = PAIR_W,
    parameter int IDW  = ID_W,
    parameter int CLSB = CTX_LSB
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         capture,
    input  logic [W-1:0] addr,
    input  logic         wr_ctx,
    input  logic         wr_ehi,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] badvaddr,
    output logic [W-1:0] context_q,
    output logic [W-1:0] entryhi
);

    localparam int VPN2_W = W - PW;
    localparam int CMSB   = CLSB + VPN2_W - 1;
    localparam int GAP_W  = PW - IDW;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            badvaddr  <= '0;
            context_q <= '0;
            entryhi   <= '0;
        end else if (capture) begin
            badvaddr              <= addr;
            context_q[CMSB:CLSB]  <= addr[W-1:PW];
            entryhi               <= {addr[W-1:PW], {GAP_W{1'b0}}, entryhi[IDW-1:0]};
        end else begin
            if (wr_ctx) context_q <= wr_data;
            if (wr_ehi) entryhi   <= wr_data;
        end
    end

    p_badvaddr_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
        capture |=> badvaddr == $past(addr));

    p_context_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
        capture |=> (context_q[CLSB-1:0] == $past(context_q[CLSB-1:0]))
                 && (context_q[W-1:CMSB+1] == $past(context_q[W-1:CMSB+1])));

    p_entryhi_id_r6: assert property (@(posedge clk) disable iff (!rst_n)
        capture |=> entryhi[IDW-1:0] == $past(entryhi[IDW-1:0]));

endmodule

// File: rtl/exc_entry_unit.sv
module exc_entry_unit
    import exc_pkg::*;
#(
    parameter logic [AW-1:0] NMI_VEC = 32'hBFC0_0000
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    input  logic [4:0]             req_code,
    input  logic                   req_refill,
    input  logic                   req_nmi,
    input  logic [1:0]             req_ce,
    input  logic [AW-1:0]          pc_in,
    input  logic                   in_delay_slot,
    input  logic [AW-1:0]          fault_addr,
    input  logic [AW-BASE_LSB-1:0] exc_base_hi,
    input  logic                   iv_in,
    input  logic                   eret_valid,
    input  logic                   csr_wr_en,
    input  logic [1:0]             csr_wr_sel,
    input  logic [AW-1:0]          csr_wr_data,
    output logic                   redirect_valid,
    output logic [AW-1:0]          redirect_pc,
    output logic [AW-1:0]          epc_out,
    output logic [AW-1:0]          errorepc_out,
    output logic [AW-1:0]          cause_out,
    output logic [3:0]             status_out,
    output logic [AW-1:0]          badvaddr_out,
    output logic [AW-1:0]          context_out,
    output logic [AW-1:0]          entryhi_out
);

    exc_state_e   state_q, state_d;
    status_t      sts_q;
    logic [AW-1:0] epc_q, errorepc_q, redir_q;
    logic          bd_q;
    logic [1:0]    ce_q;
    logic [4:0]    code_q;

    logic          take, resume, csr_ok;
    logic [AW-1:0] restart_pc, vec;
    logic          capture;

    assign take       = req_valid;
    assign resume     = eret_valid && !req_valid;
    assign csr_ok     = csr_wr_en && !req_valid && !eret_valid;
    assign restart_pc = in_delay_slot ? (pc_in - AW'(4)) : pc_in;
    assign capture    = take && !req_nmi && is_addr_fault(req_code);

    exc_vector_sel u_vec (
        .bev     (sts_q.bev),
        .base_hi (exc_base_hi),
        .code    (req_code),
        .refill  (req_refill),
        .exl     (sts_q.exl),
        .iv      (iv_in),
        .vec     (vec)
    );

    exc_fault_capture u_fault (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture   (capture),
        .addr      (fault_addr),
        .wr_ctx    (csr_ok && (csr_wr_sel == SEL_CONTEXT)),
        .wr_ehi    (csr_ok && (csr_wr_sel == SEL_ENTRYHI)),
        .wr_data   (csr_wr_data),
        .badvaddr  (badvaddr_out),
        .context_q (context_out),
        .entryhi   (entryhi_out)
    );

    // Next-state choice
    always_comb begin
        state_d = ST_IDLE;
        unique case (state_q)
            ST_IDLE, ST_TAKE, ST_RETURN: begin
                if (take)        state_d = ST_TAKE;
                else if (resume) state_d = ST_RETURN;
                else             state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Architectural registers and redirect target
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sts_q      <= '{nmi: 1'b0, bev: 1'b1, erl: 1'b0, exl: 1'b0};
            epc_q      <= '0;
            errorepc_q <= '0;
            redir_q    <= '0;
            bd_q       <= 1'b0;
            ce_q       <= '0;
            code_q     <= '0;
        end else if (take && req_nmi) begin
            errorepc_q <= restart_pc;
            sts_q.erl  <= 1'b1;
            sts_q.bev  <= 1'b1;
            sts_q.nmi  <= 1'b1;
            redir_q    <= NMI_VEC;
        end else if (take) begin
            if (!sts_q.exl) begin
                epc_q     <= restart_pc;
                bd_q      <= in_delay_slot;
                sts_q.exl <= 1'b1;
            end
            code_q  <= req_code;
            if (req_code == EC_CPU) ce_q <= req_ce;
            redir_q <= vec;
        end else if (resume) begin
            if (sts_q.erl) begin
                sts_q.erl <= 1'b0;
                redir_q   <= errorepc_q;
            end else begin
                sts_q.exl <= 1'b0;
                redir_q   <= epc_q;
            end
        end else if (csr_ok && (csr_wr_sel == SEL_STATUS)) begin
            sts_q <= status_t'(csr_wr_data[3:0]);
        end
    end

    // Outputs
    always_comb begin
        redirect_valid = 1'b0;
        unique case (state_q)
            ST_TAKE, ST_RETURN: redirect_valid = 1'b1;
            ST_IDLE:            redirect_valid = 1'b0;
            default:            redirect_valid = 1'b0;
        endcase
        redirect_pc  = redir_q;
        epc_out      = epc_q;
        errorepc_out = errorepc_q;
        status_out   = sts_q;
        cause_out    = '0;
        cause_out[31]    = bd_q;
        cause_out[29:28] = ce_q;
        cause_out[23]    = iv_in;
        cause_out[6:2]   = code_q;
    end

    p_redirect_follows_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid || eret_valid) |=> redirect_valid);

    p_pulse_ends_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_valid && !eret_valid) |=> !redirect_valid);

    p_level_set_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_nmi) |=> status_out[0]);

    p_epc_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_nmi && status_out[0]) |=> ($stable(epc_out) && $stable(cause_out[31])));

    p_nmi_target_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_nmi) |=> (redirect_pc == NMI_VEC) && status_out[1] && $stable(epc_out));

    p_return_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (eret_valid && !req_valid && !status_out[1]) |=> !status_out[0]);

    p_request_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && eret_valid && !req_nmi) |=> status_out[0]);

endmodule

// File: tb/tb_exc_entry_unit.sv
module tb_exc_entry_unit;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 5000;
    localparam int NV         = 8;

    // {code, refill, ds, bev, exl, iv, pc, expected redirect}
    localparam logic [73:0] VEC [0:NV-1] = '{
        {5'd2,  1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0040_0100, 32'h8000_1000},
        {5'd2,  1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 32'h0040_0110, 32'h8000_1180},
        {5'd0,  1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 32'h0040_0120, 32'h8000_1200},
        {5'd0,  1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 32'h0040_0130, 32'hBFC0_0380},
        {5'd3,  1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 32'h0040_0140, 32'hBFC0_0200},
        {5'd8,  1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 32'h0040_0200, 32'h8000_1180},
        {5'd0,  1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 32'h0040_0150, 32'hBFC0_0400},
        {5'd12, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 32'h0040_0160, 32'hBFC0_0380}
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid, req_refill, req_nmi, in_delay_slot, iv_in, eret_valid, csr_wr_en;
    logic [4:0]  req_code;
    logic [1:0]  req_ce, csr_wr_sel;
    logic [31:0] pc_in, fault_addr, csr_wr_data;
    logic [21:0] exc_base_hi;
    logic        redirect_valid;
    logic [31:0] redirect_pc, epc_out, errorepc_out, cause_out, badvaddr_out, context_out, entryhi_out;
    logic [3:0]  status_out;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    exc_entry_unit dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_code(req_code),
        .req_refill(req_refill), .req_nmi(req_nmi), .req_ce(req_ce), .pc_in(pc_in),
        .in_delay_slot(in_delay_slot), .fault_addr(fault_addr), .exc_base_hi(exc_base_hi),
        .iv_in(iv_in), .eret_valid(eret_valid), .csr_wr_en(csr_wr_en),
        .csr_wr_sel(csr_wr_sel), .csr_wr_data(csr_wr_data),
        .redirect_valid(redirect_valid), .redirect_pc(redirect_pc), .epc_out(epc_out),
        .errorepc_out(errorepc_out), .cause_out(cause_out), .status_out(status_out),
        .badvaddr_out(badvaddr_out), .context_out(context_out), .entryhi_out(entryhi_out)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic idle_inputs();
        req_valid = 0; req_refill = 0; req_nmi = 0; req_code = '0; req_ce = '0;
        eret_valid = 0; csr_wr_en = 0; csr_wr_sel = '0; csr_wr_data = '0;
    endtask

    task automatic csr_write(input logic [1:0] sel, input logic [31:0] data);
        @(negedge clk);
        csr_wr_en = 1; csr_wr_sel = sel; csr_wr_data = data;
        @(negedge clk);
        idle_inputs();
    endtask

    task automatic request(input logic [4:0] code, input logic refill, input logic nmi,
                           input logic [1:0] ce, input logic [31:0] pc, input logic ds,
                           input logic [31:0] addr);
        @(negedge clk);
        req_valid = 1; req_code = code; req_refill = refill; req_nmi = nmi; req_ce = ce;
        pc_in = pc; in_delay_slot = ds; fault_addr = addr;
        @(negedge clk);
        idle_inputs();
    endtask

    task automatic eret();
        @(negedge clk);
        eret_valid = 1;
        @(negedge clk);
        idle_inputs();
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        errors++;
        $display("FAIL R8 watchdog act=running exp=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] prev_epc, prev_bv, exp_epc;
        logic        prev_bd;
        idle_inputs();
        pc_in = '0; in_delay_slot = 0; fault_addr = '0; iv_in = 0;
        exc_base_hi = 22'(32'h8000_1234 >> 10);
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R11 reset state
        chk("R11 status", 32'(status_out), 32'h4);
        chk("R11 epc", epc_out, 0);
        chk("R11 errorepc", errorepc_out, 0);
        chk("R11 cause", cause_out, 0);
        chk("R11 badvaddr", badvaddr_out, 0);
        chk("R11 redirect_valid", 32'(redirect_valid), 0);

        // R1 R2 R3 R4 R5 table walk
        for (int i = 0; i < NV; i++) begin
            logic [73:0] e;
            e = VEC[i];
            csr_write(2'd0, {28'd0, 1'b0, e[66], 1'b0, e[65]});
            iv_in = e[64];
            prev_epc = epc_out;
            prev_bd  = cause_out[31];
            request(e[73:69], e[68], 1'b0, 2'd0, e[63:32], e[67], 32'h0);
            exp_epc = e[65] ? prev_epc : (e[67] ? e[63:32] - 32'd4 : e[63:32]);
            chk("R3 R4 vector", redirect_pc, e[31:0]);
            chk("R8 pulse", 32'(redirect_valid), 1);
            chk(e[65] ? "R2 epc kept" : "R1 epc", epc_out, exp_epc);
            chk(e[65] ? "R2 bd kept" : "R1 bd", 32'(cause_out[31]), 32'(e[65] ? prev_bd : e[67]));
            chk("R5 code", 32'(cause_out[6:2]), 32'(e[73:69]));
            chk("R1 exl set", 32'(status_out[0]), 1);
        end
        iv_in = 0;
        @(negedge clk);
        chk("R8 pulse ends", 32'(redirect_valid), 0);

        // R5 coprocessor number
        csr_write(2'd0, 32'h4);
        request(5'd11, 1'b0, 1'b0, 2'd2, 32'h100, 1'b0, 32'h0);
        chk("R5 ce field", 32'(cause_out[29:28]), 2);
        chk("R5 code11", 32'(cause_out[6:2]), 11);

        // R6 fault capture
        csr_write(2'd1, 32'hFFFF_FFFF);
        csr_write(2'd2, 32'hFFFF_FF5A);
        csr_write(2'd0, 32'h0);
        request(5'd2, 1'b0, 1'b0, 2'd0, 32'h200, 1'b0, 32'h1234_5678);
        chk("R6 badvaddr", badvaddr_out, 32'h1234_5678);
        chk("R6 context", context_out, 32'hFF89_1A2F);
        chk("R6 entryhi", entryhi_out, 32'h1234_405A);
        prev_bv = badvaddr_out;
        request(5'd8, 1'b0, 1'b0, 2'd0, 32'h300, 1'b0, 32'hDEAD_BEEF);
        chk("R6 no capture for code 8", badvaddr_out, prev_bv);
        chk("R6 context unchanged", context_out, 32'hFF89_1A2F);

        // R7 NMI
        csr_write(2'd0, 32'h0);
        prev_epc = epc_out;
        request(5'd0, 1'b0, 1'b1, 2'd0, 32'h0000_1000, 1'b1, 32'h0);
        chk("R7 target", redirect_pc, 32'hBFC0_0000);
        chk("R7 errorepc", errorepc_out, 32'h0000_0FFC);
        chk("R7 status", 32'(status_out), 32'hE);
        chk("R7 epc untouched", epc_out, prev_epc);

        // R9 returns
        eret();
        chk("R9 erl target", redirect_pc, 32'h0000_0FFC);
        chk("R9 erl cleared", 32'(status_out), 32'hC);
        csr_write(2'd0, 32'h1);
        eret();
        chk("R9 exl target", redirect_pc, epc_out);
        chk("R9 exl cleared", 32'(status_out[0]), 0);

        // R10 request and return together
        csr_write(2'd0, 32'h5);
        @(negedge clk);
        req_valid = 1; req_code = 5'd13; pc_in = 32'h400; in_delay_slot = 0; eret_valid = 1;
        @(negedge clk);
        idle_inputs();
        chk("R10 vector wins", redirect_pc, 32'hBFC0_0380);
        chk("R10 exl held", 32'(status_out[0]), 1);
        chk("R10 code", 32'(cause_out[6:2]), 13);

        // R12 load ignored under a request, then applied alone
        @(negedge clk);
        req_valid = 1; req_code = 5'd9; csr_wr_en = 1; csr_wr_sel = 2'd0; csr_wr_data = 32'h0;
        @(negedge clk);
        idle_inputs();
        chk("R12 load ignored", 32'(status_out), 32'h5);
        csr_write(2'd0, 32'h0);
        chk("R12 load applied", 32'(status_out), 32'h0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule